// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block holds a 32-bit reset-cause word whose top five bits record why the system last went through reset and let software ask for a new one. A power-on cause is latched only on the first device reset after power-up. Two button-cause bits can be cleared by software and set from a debug input. Writing a one to either of the two soft-request bits leaves that bit set and asks the system for a reset.

The register sits in an eight-byte window on a simple word bus. The upper word of the window holds the register. The lower word always reads zero and ignores writes. A saturating counter of device resets decides whether a reset counts as the first one. A soft power-on write clears that counter, so the next device reset records a power-on cause again. The system reset request is a registered pulse that lasts one clock.

Top module: `rst_cause_reg`

## Requirements
- R1: After `rst` the cause word is 0x00000000, `rdata` is 0, `sys_rst_req` is 0 and `first_reset` is 0.
- R2: Only bits 31..27 of the cause word can ever be one. Bits 26..0 of written data have no effect.
- R3: Writing one to bit 31 (power-on cause), bit 28 (button power-on) or bit 27 (button external) clears that bit. Writing zero to it leaves it unchanged.
- R4: Writing one to bit 30 (soft power-on) or bit 29 (soft external) sets that bit. Writing zero never clears it.
- R5: A register write with bit 30 or bit 29 set makes `sys_rst_req` high for exactly the one cycle that follows the write. No other event raises it.
- R6: A write with bit 30 set clears the device-reset counter, so the next `dev_rst` is treated as a first reset.
- R7: On `dev_rst`, if the counter is zero, the cause word becomes 0x80000000 and `first_reset` goes to 1. Otherwise the word is unchanged and `first_reset` goes to 0. Every `dev_rst` increments the counter.
- R8: The counter saturates at 2^CNT_W-1 and never wraps, so any number of further `dev_rst` cycles never sets bit 31 again.
- R9: The register answers only at the aligned byte address BASE_ADDR+4 (0xF024 by default). A read at BASE_ADDR or at any other address returns 0, and a write there changes nothing.
- R10: `dbg_btn[1]` sets bit 28 and `dbg_btn[0]` sets bit 27. If a write clears a bit in the same cycle that the debug input sets it, the set wins. In a cycle with `dev_rst`, writes and `dbg_btn` are ignored and no request is raised.
- R11: `rdata` is registered. It shows the word as it stood before the edge in the cycle after `rd_en`, and it is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| dev_rst | input | 1 | Device reset event, one cycle per reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address within the block's window |
| wdata | input | 32 | Write data |
| dbg_btn | input | 2 | Debug set of button causes: [1] power-on, [0] external |
| rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request |
| first_reset | output | 1 | Last device reset was the first since power-up or soft power-on |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle and that `dev_rst` is a separate pulse. No assertion depends on how long a strobe is held. The stimulus issues one bus operation per task call and drives every input on the falling edge. It overlaps `dev_rst` or `dbg_btn` with a write only in the directed priority cases. A behavioural model in the bench follows the counter as a plain integer, so saturation is checked against arithmetic and not against the RTL's counter width.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [DATA_W-1:0] KEEP_MASK = 32'hF800_0000;
  localparam logic [DATA_W-1:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [DATA_W-1:0] SET_MASK  = 32'h6000_0000;
  localparam logic [DATA_W-1:0] POR_VAL   = 32'h8000_0000;

  localparam int unsigned BIT_POR  = 31;
  localparam int unsigned BIT_SPOR = 30;
  localparam int unsigned BIT_SXIR = 29;
  localparam int unsigned BIT_BPOR = 28;
  localparam int unsigned BIT_BXIR = 27;
endpackage

// File: rtl/rc_decode.sv
module rc_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_reg
);
  localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(4);

  always_comb begin
    hit_reg = (addr == REG_ADDR);
  end
endmodule

// File: rtl/rc_counter.sv
module rc_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dev_rst,
  input  logic clr,
  output logic is_zero,
  output logic first_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (dev_rst) begin
      first_q <= (cnt_q == '0);
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end else if (clr) begin
      cnt_q <= '0;
    end
  end

  always_comb is_zero = (cnt_q == '0);

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (dev_rst && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R8
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (clr && !dev_rst) |=> is_zero); // R6
endmodule

// File: rtl/rc_cause.sv
module rc_cause
  import rc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic              cnt_zero,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        dbg_btn,
  output logic [DATA_W-1:0] cause_q
);
  logic [DATA_W-1:0] wmask_d;
  logic [DATA_W-1:0] dbg_d;
  logic [DATA_W-1:0] next_d;

  always_comb begin
    wmask_d = wr_hit ? (wdata & KEEP_MASK) : '0;
    dbg_d   = '0;
    dbg_d[BIT_BPOR] = dbg_btn[1];
    dbg_d[BIT_BXIR] = dbg_btn[0];
    next_d  = ((cause_q & ~(wmask_d & W1C_MASK)) | (wmask_d & SET_MASK)) | dbg_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else if (dev_rst) begin
      if (cnt_zero) cause_q <= POR_VAL;
    end else begin
      cause_q <= next_d;
    end
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cause_q & ~KEEP_MASK) == '0); // R2
  AST_POR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (dev_rst && cnt_zero) |=> (cause_q == POR_VAL)); // R7
  AST_SOFT_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(cause_q[BIT_SPOR]) |-> $past(dev_rst)); // R4
  AST_DBG_WINS: assert property (@(posedge clk) disable iff (rst)
    (!dev_rst && dbg_btn[1]) |=> cause_q[BIT_BPOR]); // R10
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int unsigned CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        dbg_btn,
  output logic [31:0]       rdata,
  output logic              sys_rst_req,
  output logic              first_reset
);
  logic              hit_reg;
  logic              wr_hit;
  logic              cnt_zero;
  logic              soft_req;
  logic [DATA_W-1:0] cause_q;

  rc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr    (addr),
    .hit_reg (hit_reg)
  );

  always_comb begin
    wr_hit   = wr_en && hit_reg;
    soft_req = wr_hit && !dev_rst && ((wdata & SET_MASK) != '0);
  end

  rc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .dev_rst (dev_rst),
    .clr     (wr_hit && wdata[BIT_SPOR]),
    .is_zero (cnt_zero),
    .first_q (first_reset)
  );

  rc_cause u_cause (
    .clk      (clk),
    .rst      (rst),
    .dev_rst  (dev_rst),
    .cnt_zero (cnt_zero),
    .wr_hit   (wr_hit),
    .wdata    (wdata),
    .dbg_btn  (dbg_btn),
    .cause_q  (cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      rdata       <= (rd_en && hit_reg) ? cause_q : '0;
      sys_rst_req <= soft_req;
    end
  end

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(wr_en && hit_reg && !dev_rst && (wdata[30] || wdata[29]))); // R5
  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0)); // R11
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !hit_reg) |-> (rdata == '0)); // R9
endmodule

// File: tb/sim_rst_cause_reg.sv
`timescale 1ns/1ps
module sim_rst_cause_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_rst = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  dbg_btn = '0;
  logic [31:0] rdata;
  logic        sys_rst_req;
  logic        first_reset;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rst_cause_reg u0 (
    .clk(clk), .rst(rst), .dev_rst(dev_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .dbg_btn(dbg_btn), .rdata(rdata),
    .sys_rst_req(sys_rst_req), .first_reset(first_reset)
  );

  // behavioural reference model
  logic [31:0] m_reg = '0;
  int          m_cnt = 0;
  logic        m_first = 0, m_req = 0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    logic [31:0] v;
    logic [31:0] n;
    logic        hit;
    hit = (addr == 16'hF024);
    if (rst) begin
      m_reg = 0; m_cnt = 0; m_first = 0; m_req = 0; m_rdata = 0;
    end else begin
      m_rdata = (rd_en && hit) ? m_reg : 32'h0;
      m_req   = !dev_rst && wr_en && hit && (wdata[30] || wdata[29]);
      if (dev_rst) begin
        m_first = (m_cnt == 0);
        if (m_cnt == 0) m_reg = 32'h8000_0000;
        if (m_cnt < 15) m_cnt = m_cnt + 1;
      end else begin
        n = m_reg;
        if (wr_en && hit) begin
          v = wdata & 32'hF800_0000;
          n = n & ~(v & 32'h9800_0000);
          n = n | (v & 32'h6000_0000);
          if (v[30]) m_cnt = 0;
        end
        if (dbg_btn[1]) n[28] = 1'b1;
        if (dbg_btn[0]) n[27] = 1'b1;
        m_reg = n;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      checks++;
      if (rdata !== m_rdata) begin
        failures++;
        $display("FAIL R11 model rdata actual=%h expected=%h", rdata, m_rdata);
      end
      if (sys_rst_req !== m_req) begin
        failures++;
        $display("FAIL R5 model req actual=%0b expected=%0b", sys_rst_req, m_req);
      end
      if (first_reset !== m_first) begin
        failures++;
        $display("FAIL R7 model first actual=%0b expected=%0b", first_reset, m_first);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse_dev();
    @(negedge clk); dev_rst = 1;
    @(negedge clk); dev_rst = 0;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 req after reset", {31'b0, sys_rst_req}, 0);
    chk("R1 first after reset", {31'b0, first_reset}, 0);
    rst = 0;
    rd(16'hF024, d); chk("R1 word after reset", d, 32'h0);

    pulse_dev();
    chk("R7 first on initial dev reset", {31'b0, first_reset}, 1);
    rd(16'hF024, d); chk("R7 power-on cause", d, 32'h8000_0000);
    pulse_dev();
    chk("R7 second dev reset not first", {31'b0, first_reset}, 0);
    rd(16'hF024, d); chk("R7 word unchanged", d, 32'h8000_0000);

    wr(16'hF024, 32'h07FF_FFFF);
    chk("R2 no request from low bits", {31'b0, sys_rst_req}, 0);
    rd(16'hF024, d); chk("R2 low data ignored", d, 32'h8000_0000);
    wr(16'hF024, 32'h0);
    rd(16'hF024, d); chk("R3 zero write keeps", d, 32'h8000_0000);

    @(negedge clk); dbg_btn = 2'b11; @(negedge clk); dbg_btn = 0;
    rd(16'hF024, d); chk("R10 debug sets buttons", d, 32'h9800_0000);
    wr(16'hF024, 32'h1000_0000);
    rd(16'hF024, d); chk("R3 clear bit 28", d, 32'h8800_0000);

    wr(16'hF024, 32'h2000_0000);
    chk("R5 request pulse", {31'b0, sys_rst_req}, 1);
    @(negedge clk); chk("R5 pulse one cycle", {31'b0, sys_rst_req}, 0);
    rd(16'hF024, d); chk("R4 soft external set", d, 32'hA800_0000);

    wr(16'hF020, 32'hF800_0000);
    chk("R9 low word no request", {31'b0, sys_rst_req}, 0);
    rd(16'hF020, d); chk("R9 low word reads zero", d, 32'h0);
    wr(16'hF025, 32'hF800_0000);
    rd(16'hF024, d); chk("R9 unaligned ignored", d, 32'hA800_0000);

    wr(16'hF024, 32'h4000_0000);
    chk("R5 soft power-on request", {31'b0, sys_rst_req}, 1);
    rd(16'hF024, d); chk("R4 soft power-on set", d, 32'hE800_0000);
    pulse_dev();
    chk("R6 counter cleared first", {31'b0, first_reset}, 1);
    rd(16'hF024, d); chk("R6 power-on reloaded", d, 32'h8000_0000);

    // same-cycle priority cases
    @(negedge clk); dev_rst = 1; wr_en = 1; addr = 16'hF024; wdata = 32'h6000_0000;
    @(negedge clk); dev_rst = 0; wr_en = 0; wdata = 0;
    chk("R10 write dropped under dev reset", {31'b0, sys_rst_req}, 0);
    rd(16'hF024, d); chk("R10 word after dropped write", d, 32'h8000_0000);
    @(negedge clk); dbg_btn = 2'b10; wr_en = 1; addr = 16'hF024; wdata = 32'h9000_0000;
    @(negedge clk); dbg_btn = 0; wr_en = 0; wdata = 0;
    rd(16'hF024, d); chk("R10 debug set beats clear", d, 32'h1000_0000);

    wr(16'hF024, 32'h1000_0000);
    for (int i = 0; i < 20; i++) pulse_dev();
    chk("R8 no wrap first", {31'b0, first_reset}, 0);
    rd(16'hF024, d); chk("R8 no power-on after saturation", d, 32'h0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule